// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves a received byte stream into memory buffers that software lends to it through a ring of descriptors. Each descriptor is four 16-bit halfwords placed 8 bytes apart: a status word at offset 0, a byte count at offset 2, and the upper and lower halves of the 32-bit buffer address at offsets 4 and 6. The engine reads descriptors and writes data through one halfword-wide memory port. A read returns its data in the cycle after the request. Status bit 15 gives ownership: 1 means the engine may fill the buffer. The engine clears it when it hands the buffer back.

The byte stream carries start-of-frame and end-of-frame markers. One frame can fill several buffers, but a buffer never holds bytes from two frames. For each buffer it closes, the engine writes the byte count, then a status word that marks whether the buffer opened and/or closed a frame. It may also report an overrun and pulse the interrupt line. The ring starts at `ring_base`. A descriptor with its wrap bit set sends the engine back to that base. The engine does not poll memory on its own. A pulse on `poll_kick` makes it read the current descriptor. From then on it moves through the ring until it meets a descriptor that software still owns.

Control is one state machine. `STALL` waits for a kick and drops input. `FETCH` reads the status word. `EVAL` tests ownership: it goes to `PTRHI` if owned and back to `STALL` if not. `PTRHI` and `PTRLO` collect the buffer address. `FILL` writes bytes. `WB_LEN` writes the count. `WB_STAT` writes the status and steps to the next descriptor, then returns to `FETCH`. `FILL` moves to `WB_LEN` on end of frame, on a full buffer, or on an early start of frame.

Top module: `rxbd_rx_dma`

## Requirements
- R1: Descriptor i sits at ring address + 8*i. The engine reads the status at +0, the address upper half at +4 and the lower half at +6, and it writes the byte count to +2. Every halfword access uses both byte enables and an even address.
- R2: The engine uses only a descriptor whose status bit 15 reads 1. The status it writes back has bit 15 cleared. Bit 14 (wrap) and bit 13 (interrupt enable) keep their read values, and all other bits not named in R4 and R9 are written as 0.
- R3: The first kick after reset loads the descriptor pointer from `ring_base`. After a descriptor whose bit 14 is set, the next descriptor is at `ring_base`; otherwise it is 8 bytes further on. Bit 14 never ends a frame.
- R4: Status bit 12 (first) is set in the buffer that received a start-of-frame byte. Status bit 11 (last) is set in the buffer that received the end-of-frame byte.
- R5: A buffer holds at most BUF_BYTES bytes. A buffer that fills inside a frame is closed with count BUF_BYTES and no last bit, and the frame continues in the next descriptor. After an end of frame, the next frame starts in a new buffer.
- R6: `irq` is a single-cycle pulse, given in the cycle the status word is written back, and only when that descriptor's bit 13 is set.
- R7: When a fetched descriptor is not owned, the engine makes no memory access until `poll_kick` is pulsed. The kick re-reads the same descriptor.
- R8: A start-of-frame byte that arrives while the open buffer already holds bytes closes that buffer with its current count and no last bit. The new frame then starts in the next buffer with the first bit set.
- R9: While stalled, the engine accepts and discards input bytes. A frame that loses bytes this way is dropped up to the next start of frame, and the next status written back has bit 0 (overrun) set.
- R10: Byte k of a buffer is written to buffer address + k with one byte enable. An even address uses the upper lane (`mem_be`=2'b10, data in bits 15:8); an odd address uses the lower lane (2'b01, data in bits 7:0).
- R11: After reset, `irq` and `mem_req` are 0 and `in_ready` is 1, and no memory access happens before the first kick.
- R12: `in_ready` is 0 while a descriptor is being read or written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_base | input | 32 | Byte address of descriptor 0 |
| poll_kick | input | 1 | One-cycle request to read the current descriptor |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Input byte is taken on this edge |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 2 | Byte enables, bit 1 = even-address byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| irq | output | 1 | Buffer hand-back interrupt pulse |

## Verification
Each byte is written to memory on the same edge that accepts it. The count follows on the next edge and the status, together with the interrupt pulse, on the one after that. The engine then spends four cycles reading the next descriptor and has `in_ready` low meanwhile. The bench therefore waits twelve cycles after the last byte of a frame before it reads the descriptors back, and it samples `in_ready`, `irq` and `mem_req` at falling edges. The one timing check is exact: `in_ready` must be low one cycle after a kick, while the status read is in flight.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    typedef enum logic [3:0] {
        S_STALL,
        S_FETCH,
        S_EVAL,
        S_PTRHI,
        S_PTRLO,
        S_FILL,
        S_WB_LEN,
        S_WB_STAT
    } rx_state_e;

    // status word bit positions
    localparam int B_OWN   = 15;
    localparam int B_WRAP  = 14;
    localparam int B_IRQ   = 13;
    localparam int B_FIRST = 12;
    localparam int B_LAST  = 11;
    localparam int B_OVR   = 0;

    // descriptor geometry (byte offsets)
    localparam int OFS_STAT   = 0;
    localparam int OFS_LEN    = 2;
    localparam int OFS_PHI    = 4;
    localparam int OFS_PLO    = 6;
    localparam int DESC_BYTES = 8;
    localparam int ADDR_W     = 32;
    localparam int HW_W       = 16;

endpackage

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr
    import rxbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic              step,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] cur
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load_base) begin
            cur <= base;
        end else if (step) begin
            cur <= wrap ? base : cur + ADDR_W'(DESC_BYTES);
        end
    end

endmodule

// File: rtl/rxbd_fill.sv
module rxbd_fill #(
    parameter int BUF_BYTES = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             last_slot,
    output logic             has_data
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BUF_BYTES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last_slot = (cnt == LAST_IDX);
    assign has_data  = (cnt != '0);

endmodule

// File: rtl/rxbd_fsm.sv
module rxbd_fsm
    import rxbd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_kick,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] cur_desc,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              last_slot,
    input  logic              has_data,
    output logic              load_base,
    output logic              ring_step,
    output logic              ring_wrap,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [HW_W-1:0]   mem_wdata,
    input  logic [HW_W-1:0]   mem_rdata,
    output logic              irq,
    output rx_state_e         state_o
);

    rx_state_e state_q, state_d;

    logic              started_q;
    logic              wrap_q, irqen_q;
    logic [HW_W-1:0]   phi_q;
    logic [ADDR_W-1:0] bufp_q;
    logic              first_q, close_last_q, ovr_q;
    logic              in_frame_q, drop_q;

    logic abort_hit, acc, keep, wr_byte, close_now, lose_byte, owned;
    logic [ADDR_W-1:0] byte_addr;
    logic [HW_W-1:0]   wb_status;

    // input-side decode
    assign abort_hit = (state_q == S_FILL) && in_valid && in_sof && has_data;
    assign in_ready  = (state_q == S_STALL) || ((state_q == S_FILL) && !abort_hit);
    assign acc       = in_valid && in_ready;
    assign keep      = in_sof || (in_frame_q && !drop_q);
    assign wr_byte   = acc && (state_q == S_FILL) && keep;
    assign close_now = wr_byte && (in_eof || last_slot);
    assign lose_byte = acc && (state_q == S_STALL) && keep;
    assign owned     = mem_rdata[B_OWN];
    assign byte_addr = bufp_q + ADDR_W'(cnt);

    always_comb begin
        wb_status          = '0;
        wb_status[B_WRAP]  = wrap_q;
        wb_status[B_IRQ]   = irqen_q;
        wb_status[B_FIRST] = first_q;
        wb_status[B_LAST]  = close_last_q;
        wb_status[B_OVR]   = ovr_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_STALL;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_STALL:   if (poll_kick) state_d = S_FETCH;
            S_FETCH:   state_d = S_EVAL;
            S_EVAL:    state_d = owned ? S_PTRHI : S_STALL;
            S_PTRHI:   state_d = S_PTRLO;
            S_PTRLO:   state_d = S_FILL;
            S_FILL:    if (abort_hit || close_now) state_d = S_WB_LEN;
            S_WB_LEN:  state_d = S_WB_STAT;
            S_WB_STAT: state_d = S_FETCH;
            default:   state_d = S_STALL;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_desc;
        mem_be    = 2'b11;
        mem_wdata = '0;
        irq       = 1'b0;
        ring_step = 1'b0;
        cnt_clr   = 1'b0;
        load_base = (state_q == S_STALL) && poll_kick && !started_q;
        cnt_inc   = wr_byte;
        ring_wrap = wrap_q;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc + ADDR_W'(OFS_STAT);
            end
            S_EVAL: begin
                mem_req  = owned;
                mem_addr = cur_desc + ADDR_W'(OFS_PHI);
            end
            S_PTRHI: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc + ADDR_W'(OFS_PLO);
            end
            S_FILL: begin
                mem_req  = wr_byte;
                mem_we   = 1'b1;
                mem_addr = byte_addr;
                if (byte_addr[0]) begin
                    mem_be    = 2'b01;
                    mem_wdata = {8'h00, in_data};
                end else begin
                    mem_be    = 2'b10;
                    mem_wdata = {in_data, 8'h00};
                end
            end
            S_WB_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc + ADDR_W'(OFS_LEN);
                mem_wdata = HW_W'(cnt);
            end
            S_WB_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc + ADDR_W'(OFS_STAT);
                mem_wdata = wb_status;
                irq       = irqen_q;
                ring_step = 1'b1;
                cnt_clr   = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // descriptor and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q    <= 1'b0;
            wrap_q       <= 1'b0;
            irqen_q      <= 1'b0;
            phi_q        <= '0;
            bufp_q       <= '0;
            first_q      <= 1'b0;
            close_last_q <= 1'b0;
            ovr_q        <= 1'b0;
            in_frame_q   <= 1'b0;
            drop_q       <= 1'b0;
        end else begin
            if (load_base) started_q <= 1'b1;
            if (state_q == S_EVAL && owned) begin
                wrap_q  <= mem_rdata[B_WRAP];
                irqen_q <= mem_rdata[B_IRQ];
            end
            if (state_q == S_PTRHI) phi_q  <= mem_rdata;
            if (state_q == S_PTRLO) bufp_q <= {phi_q, mem_rdata};
            if (wr_byte && in_sof) first_q <= 1'b1;
            if (abort_hit)      close_last_q <= 1'b0;
            else if (close_now) close_last_q <= in_eof;
            if (acc && in_eof)      in_frame_q <= 1'b0;
            else if (acc && in_sof) in_frame_q <= 1'b1;
            if (lose_byte)          drop_q <= 1'b1;
            else if (acc && in_sof) drop_q <= 1'b0;
            if (state_q == S_WB_STAT) begin
                first_q <= 1'b0;
                ovr_q   <= 1'b0;
            end
            if (lose_byte) ovr_q <= 1'b1;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rxbd_rx_dma.sv
module rxbd_rx_dma
    import rxbd_pkg::*;
#(
    parameter int BUF_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ring_base,
    input  logic        poll_kick,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    output logic        in_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_be,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        irq
);

    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic [ADDR_W-1:0] cur_desc;
    logic [CNT_W-1:0]  cnt;
    logic              last_slot, has_data;
    logic              load_base, ring_step, ring_wrap, cnt_clr, cnt_inc;
    rx_state_e         fsm_state;

    rxbd_ring_ptr u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (load_base),
        .step      (ring_step),
        .wrap      (ring_wrap),
        .base      (ring_base),
        .cur       (cur_desc)
    );

    rxbd_fill #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .cnt       (cnt),
        .last_slot (last_slot),
        .has_data  (has_data)
    );

    rxbd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_kick (poll_kick),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_ready  (in_ready),
        .cur_desc  (cur_desc),
        .cnt       (cnt),
        .last_slot (last_slot),
        .has_data  (has_data),
        .load_base (load_base),
        .ring_step (ring_step),
        .ring_wrap (ring_wrap),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .irq       (irq),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/rxbd_chk.sv
module rxbd_chk
    import rxbd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        poll_kick,
    input logic        in_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic        addr_lsb,
    input logic [1:0]  mem_be,
    input logic [15:0] mem_wdata,
    input logic        irq,
    input rx_state_e   st
);

    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == 2'b11) |-> !addr_lsb);

    p_wb_clears_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 2'b11) |-> !mem_wdata[B_OWN]);

    p_irq_on_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mem_req && mem_we && mem_be == 2'b11));

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STALL && !poll_kick) |=> !mem_req);

    p_stall_accepts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STALL) |-> in_ready);

    p_byte_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 2'b11) |->
            ($countones(mem_be) == 1 && mem_be[1] == !addr_lsb));

    p_read_blocks_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !in_ready);

endmodule

bind rxbd_rx_dma rxbd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_kick (poll_kick),
    .in_ready  (in_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .addr_lsb  (mem_addr[0]),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .irq       (irq),
    .st        (fsm_state)
);

// File: tb/tb_rxbd_rx_dma.sv
`timescale 1ns/1ps
module tb_rxbd_rx_dma;

    localparam int BUFB    = 8;
    localparam int RBASE   = 'h40;
    localparam int BBASE   = 'h100;
    localparam int NDESC   = 4;
    localparam logic [15:0] OWN = 16'h8000, WRP = 16'h4000, IEN = 16'h2000,
                            FST = 16'h1000, LST = 16'h0800, OVR = 16'h0001;

    logic        clk = 0, rst_n = 0;
    logic        poll_kick = 0, in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready, mem_req, mem_we, irq;
    logic [31:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, mem_rdata;

    logic [15:0] mem [0:255];
    logic        tb_we = 0;
    logic [7:0]  tb_a = 0;
    logic [15:0] tb_d = 0;

    int n_chk = 0, n_fail = 0, irq_cnt = 0, exp_irq = 0, req_cycles = 0, cyc = 0;
    int m_idx = 0;
    logic [7:0] fd [0:63];

    always #2 clk = ~clk;

    rxbd_rx_dma #(.BUF_BYTES(BUFB)) dut (
        .clk(clk), .rst_n(rst_n), .ring_base(32'(RBASE)), .poll_kick(poll_kick),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model: one-cycle read latency, byte-lane writes
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_be[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
                if (mem_be[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
            end else begin
                mem_rdata <= mem[mem_addr[8:1]];
            end
        end
        if (tb_we) mem[tb_a] <= tb_d;
    end

    always @(negedge clk) begin
        if (irq) irq_cnt++;
        if (mem_req) req_cycles++;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) act=%0d exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int dadr(input int i);
        return RBASE + 8 * i;
    endfunction

    function automatic logic [15:0] hw_read(input int a);
        return mem[a[8:1]];
    endfunction

    function automatic logic [7:0] rd_byte(input int a);
        logic [15:0] h;
        h = mem[a[8:1]];
        return a[0] ? h[7:0] : h[15:8];
    endfunction

    function automatic logic [15:0] arm_val(input int i);
        logic [15:0] v;
        v = OWN;
        if (i == NDESC - 1) v |= WRP;
        if (i % 2 == 0) v |= IEN;
        return v;
    endfunction

    task automatic hw_write(input int a, input logic [15:0] d);
        @(negedge clk);
        tb_we = 1; tb_a = a[8:1]; tb_d = d;
        @(negedge clk);
        tb_we = 0;
    endtask

    task automatic arm(input int i);
        hw_write(dadr(i), arm_val(i));
        hw_write(dadr(i) + 2, 16'h0);
    endtask

    task automatic kick();
        @(negedge clk); poll_kick = 1;
        @(negedge clk); poll_kick = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
        in_valid = 1; in_data = d; in_sof = s; in_eof = e;
        #0.5;
        while (!in_ready) begin @(negedge clk); #0.5; end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0;
    endtask

    // send fd[off..off+n-1] as one frame
    task automatic send_seg(input int off, input int n, input bit s, input bit e);
        for (int k = 0; k < n; k++)
            send_byte(fd[off + k], s && k == 0, e && k == n - 1);
    endtask

    task automatic chk_chunk(input int di, input int off, input int len,
                             input bit f, input bit l, input bit ov, input string tag);
        logic [15:0] es;
        int bad;
        es = 16'h0;
        if (di == NDESC - 1) es |= WRP;
        if (di % 2 == 0) es |= IEN;
        if (f) es |= FST;
        if (l) es |= LST;
        if (ov) es |= OVR;
        if (di % 2 == 0) exp_irq++;
        check({tag, " R2 R4 status"}, 32'(hw_read(dadr(di))), 32'(es));
        check({tag, " R1 R5 length"}, 32'(hw_read(dadr(di) + 2)), 32'(len));
        bad = 0;
        for (int k = 0; k < len; k++)
            if (rd_byte(BBASE + 16 * di + k) !== fd[off + k]) bad++;
        check({tag, " R10 data"}, 32'(bad), 32'd0);
    endtask

    // expected placement of a clean frame starting at m_idx
    task automatic run_frame(input int n, input bit ov, input string tag);
        int off;
        int len;
        for (int k = 0; k < n; k++) fd[k] = 8'($urandom);
        send_seg(0, n, 1, 1);
        settle();
        off = 0;
        while (off < n) begin
            len = (n - off > BUFB) ? BUFB : n - off;
            chk_chunk(m_idx, off, len, off == 0, off + len == n, ov && off == 0, tag);
            m_idx = (m_idx + 1) % NDESC;
            off += len;
        end
        check({tag, " R6 irq count"}, 32'(irq_cnt), 32'(exp_irq));
    endtask

    initial begin
        int rs;
        int r0;
        rs = $urandom(32'd7321);
        // ring setup while in reset
        for (int i = 0; i < NDESC; i++) begin
            arm(i);
            hw_write(dadr(i) + 4, 16'h0);
            hw_write(dadr(i) + 6, 16'(BBASE + 16 * i));
        end
        @(negedge clk); rst_n = 1;
        repeat (4) @(negedge clk);
        check("R11 in_ready after reset", 32'(in_ready), 32'd1);
        check("R11 irq after reset", 32'(irq), 32'd0);
        check("R11 R7 no access before kick", 32'(req_cycles), 32'd0);

        // first kick loads base; in_ready low while status read is in flight
        @(negedge clk); poll_kick = 1;
        @(negedge clk); poll_kick = 0;
        check("R12 in_ready during fetch", 32'(in_ready), 32'd0);
        settle();

        run_frame(5, 0, "F1 short");
        run_frame(20, 0, "F2 span+wrap");       // d1,d2,d3 then back to base d0 (not owned)

        // stalled: whole frame is dropped, no memory touched
        r0 = req_cycles;
        for (int k = 0; k < 6; k++) fd[k] = 8'hA0 + 8'(k);
        send_seg(0, 6, 1, 1);
        settle();
        check("R7 stall no memory access", 32'(req_cycles - r0), 32'd0);
        check("R9 dropped frame leaves status", 32'(hw_read(dadr(0))), 32'(IEN | FST | LST));
        check("R9 dropped frame leaves length", 32'(hw_read(dadr(0) + 2)), 32'd5);

        // R3: wrap returned to base; overrun reported on d0
        arm(0);
        kick();
        settle();
        run_frame(3, 1, "F4 R3 R9 after wrap");  // then d1 not owned -> stall

        for (int i = 1; i < NDESC; i++) arm(i);
        kick();
        settle();

        // R8: frame cut short by a new start of frame
        for (int k = 0; k < 6; k++) fd[k] = 8'($urandom);
        send_seg(0, 4, 1, 0);
        send_seg(4, 2, 1, 1);
        settle();
        chk_chunk(1, 0, 4, 1, 0, 0, "R8 aborted");
        chk_chunk(2, 4, 2, 1, 1, 0, "R8 next");
        check("R8 R6 irq count", 32'(irq_cnt), 32'(exp_irq));
        m_idx = 3;

        run_frame(8, 0, "F7 exact fill R5");     // d3, then d0 not owned -> stall

        // ring runs dry in mid frame
        arm(0);
        kick();
        settle();
        for (int k = 0; k < 12; k++) fd[k] = 8'($urandom);
        send_seg(0, 12, 1, 1);
        settle();
        chk_chunk(0, 0, 8, 1, 0, 0, "R5 R9 midframe");
        check("R9 R6 irq count", 32'(irq_cnt), 32'(exp_irq));
        for (int i = 1; i < NDESC; i++) arm(i);
        kick();
        settle();
        m_idx = 1;
        run_frame(3, 1, "R9 overrun midframe");
        for (int i = 0; i < NDESC; i++) arm(i);

        // random frames, ring refilled after each
        for (int t = 0; t < 30; t++) begin
            run_frame(1 + int'($urandom % 24), 0, "random");
            for (int i = 0; i < NDESC; i++) arm(i);
        end

        summary();
        $finish;
    end

endmodule